// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through eight 16-bit registers. Software loads a 32-bit transmit word as two halfwords, picks the serial clock rate and the interrupt masks, then writes one control word. That write carries the transfer length (1 to 32 bits), the target device number and the direction. Two directions exist: write-only, or full-duplex read-write. The engine asserts one active-low chip select and shifts the bits out most significant bit first in SPI mode 0.

At the end of a transfer the block releases the chip select and sets a per-direction end flag in the status register. It also raises a level interrupt unless that direction's interrupt is masked. After that it stays busy for a fixed guard time of fourteen serial half-periods, and no new transfer can start until the guard time has passed. Reading the status register clears both end flags. In read-write mode the received bits are right-aligned in the 32-bit receive word.

Top module: `spi_master_regs`

## Requirements
- R1: After reset all chip selects are high, the serial clock is low, the interrupt is low, and every register reads as zero.
- R2: Registers sit at halfword indices 0 to 7 in this order: SET1, SET2, CTRL, STATUS, TX_LSB, TX_MSB, RX_LSB, RX_MSB. SET1 keeps only bits 0, 4 and 5. SET2 keeps bits 7:0. Both transmit halves read back what was written.
- R3: A CTRL write starts a transfer when at least one of bit 0 (read-write) and bit 1 (write-only) is set and SET1 bit 0 is 1. Bits 6:2 hold the length minus one and bits 9:7 hold the device number. When SET1 bit 0 is 0, a CTRL write starts nothing.
- R4: One serial half-period lasts SET2[7:0]+1 clocks. The chip select goes low in the cycle after the CTRL write and stays low for one half-period before the first rising edge. It is released one half-period after the last falling edge, (2N+1) half-periods after the start. The serial clock idles low.
- R5: MOSI presents bit 31 of {TX_MSB, TX_LSB} first and moves to the next lower bit on each falling edge.
- R6: In read-write mode MISO is sampled on each rising edge, and after N bits {RX_MSB, RX_LSB} holds those bits right-aligned with zeros above them. A write-only transfer leaves the receive word unchanged.
- R7: Only the chip select whose index equals the device number goes low. For device numbers 5 to 7 every chip select stays high.
- R8: STATUS bit 0 (read end) is set when a read-write transfer ends and bit 1 (write end) is set when a write-only transfer ends, in the same cycle as the chip-select release. A STATUS read clears both bits.
- R9: The interrupt is high while bit 0 is set and SET1 bit 5 is 0, or while bit 1 is set and SET1 bit 4 is 0.
- R10: A CTRL write is ignored from the start of a transfer until 14 half-periods after the chip select is released.
- R11: A CTRL write with both bit 0 and bit 1 set runs a read-write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on a STATUS read) |
| bus_addr | input | 3 | Halfword register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
Let h be SET2+1 and let t be the number of clocks since the edge that took the CTRL write. The chip select is due low at t=0. The clock level during half-period k=t/h is due odd-high. The end flag, the interrupt and the chip-select release are due at t=(2N+1)h. The next start can be accepted no earlier than t=(2N+15)h. The bench keeps t in its own model and updates it on each rising edge. It compares chip selects, clock, MOSI and interrupt on every falling edge. It reads registers a quarter-cycle after it drives the address.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int WORD_W = 32;
  localparam int LEN_W  = $clog2(WORD_W);

  typedef enum logic [2:0] {
    RA_SET1 = 3'd0, RA_SET2 = 3'd1, RA_CTRL = 3'd2, RA_STAT = 3'd3,
    RA_TXL  = 3'd4, RA_TXH  = 3'd5, RA_RXL  = 3'd6, RA_RXH  = 3'd7
  } reg_idx_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL, ST_GUARD
  } eng_state_e;

  // index of the final (falling) clock edge for a length-minus-one code
  function automatic logic [LEN_W:0] last_edge(input logic [LEN_W-1:0] len_m1);
    return {len_m1, 1'b1};
  endfunction

  // true when device number dev owns chip select idx
  function automatic logic dev_owns(input logic [2:0] dev, input int idx);
    return int'(dev) == idx;
  endfunction
endpackage

// File: rtl/spi_clkdiv.sv
module spi_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode import spi_pkg::*; #(
  parameter int NUM_CS = 5
) (
  input  logic              active,
  input  logic [2:0]        dev,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = ~(active && dev_owns(dev, i));
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine import spi_pkg::*; #(
  parameter int GUARD_HALVES = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rw,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic [WORD_W-1:0] tx_word,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              cs_active,
  output logic              sclk,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word,
  output logic              done,
  output logic              done_rw
);
  localparam int GW = $clog2(GUARD_HALVES + 1);

  eng_state_e        state_q;
  logic [LEN_W:0]    edge_q, last_q;
  logic [GW-1:0]     guard_q;
  logic              rw_q, sclk_q;
  logic [WORD_W-1:0] sh_q, rx_q;

  assign busy      = (state_q != ST_IDLE);
  assign cs_active = (state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL);
  assign sclk      = sclk_q;
  assign mosi      = sh_q[WORD_W-1];
  assign rx_word   = rx_q;
  assign done      = (state_q == ST_TRAIL) && tick;
  assign done_rw   = done && rw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      last_q  <= '0;
      guard_q <= '0;
      rw_q    <= 1'b0;
      sclk_q  <= 1'b0;
      sh_q    <= '0;
      rx_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LEAD;
          sh_q    <= tx_word;
          rw_q    <= start_rw;
          last_q  <= last_edge(len_m1);
          if (start_rw) rx_q <= '0;
        end
        ST_LEAD: if (tick) begin
          sclk_q  <= 1'b1;
          if (rw_q) rx_q <= {rx_q[WORD_W-2:0], miso};
          edge_q  <= 1;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          edge_q <= edge_q + 1'b1;
          if (edge_q[0]) begin
            sclk_q <= 1'b0;
            sh_q   <= sh_q << 1;
            if (edge_q == last_q) state_q <= ST_TRAIL;
          end else begin
            sclk_q <= 1'b1;
            if (rw_q) rx_q <= {rx_q[WORD_W-2:0], miso};
          end
        end
        ST_TRAIL: if (tick) begin
          state_q <= ST_GUARD;
          guard_q <= '0;
        end
        ST_GUARD: if (tick) begin
          if (guard_q == GW'(GUARD_HALVES - 1)) state_q <= ST_IDLE;
          else guard_q <= guard_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs import spi_pkg::*; #(
  parameter int NUM_CS       = 5,
  parameter int DIV_W        = 8,
  parameter int GUARD_HALVES = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [NUM_CS-1:0] spi_cs_n
);
  logic             clk_en_q, mask_w_q, mask_rw_q;
  logic [DIV_W-1:0] div_cfg_q, div_run_q;
  logic [9:0]       ctrl_q;
  logic [15:0]      tx_lo_q, tx_hi_q;
  logic [2:0]       dev_q;
  logic             stat_re, stat_we;

  // named internal events
  logic              eng_busy, cs_active, div_tick, xfer_done, xfer_done_rw;
  logic              start_accept, stat_read;
  logic [WORD_W-1:0] rx_word;

  assign start_accept = bus_wr && (bus_addr == RA_CTRL) && !eng_busy && clk_en_q
                        && (bus_wdata[0] || bus_wdata[1]);
  assign stat_read    = bus_rd && (bus_addr == RA_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_q  <= 1'b0;
      mask_w_q  <= 1'b0;
      mask_rw_q <= 1'b0;
      div_cfg_q <= '0;
      div_run_q <= '0;
      ctrl_q    <= '0;
      tx_lo_q   <= '0;
      tx_hi_q   <= '0;
      dev_q     <= '0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          RA_SET1: begin
            clk_en_q  <= bus_wdata[0];
            mask_w_q  <= bus_wdata[4];
            mask_rw_q <= bus_wdata[5];
          end
          RA_SET2: div_cfg_q <= bus_wdata[DIV_W-1:0];
          RA_TXL:  tx_lo_q   <= bus_wdata;
          RA_TXH:  tx_hi_q   <= bus_wdata;
          default: ;
        endcase
      end
      if (start_accept) begin
        ctrl_q    <= bus_wdata[9:0];
        dev_q     <= bus_wdata[9:7];
        div_run_q <= div_cfg_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_re <= 1'b0;
      stat_we <= 1'b0;
    end else begin
      stat_re <= (stat_re && !stat_read) || xfer_done_rw;
      stat_we <= (stat_we && !stat_read) || (xfer_done && !xfer_done_rw);
    end
  end

  assign irq = (stat_re && !mask_rw_q) || (stat_we && !mask_w_q);

  always_comb begin
    case (bus_addr)
      RA_SET1: bus_rdata = {10'b0, mask_rw_q, mask_w_q, 3'b0, clk_en_q};
      RA_SET2: bus_rdata = 16'(div_cfg_q);
      RA_CTRL: bus_rdata = {6'b0, ctrl_q};
      RA_STAT: bus_rdata = {14'b0, stat_we, stat_re};
      RA_TXL:  bus_rdata = tx_lo_q;
      RA_TXH:  bus_rdata = tx_hi_q;
      RA_RXL:  bus_rdata = rx_word[15:0];
      default: bus_rdata = rx_word[31:16];
    endcase
  end

  spi_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(eng_busy), .div(div_run_q), .tick(div_tick)
  );

  spi_shift_engine #(.GUARD_HALVES(GUARD_HALVES)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(start_accept), .start_rw(bus_wdata[0]),
    .len_m1(bus_wdata[6:2]), .tx_word({tx_hi_q, tx_lo_q}),
    .tick(div_tick), .miso(spi_miso),
    .busy(eng_busy), .cs_active(cs_active),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_word(rx_word),
    .done(xfer_done), .done_rw(xfer_done_rw)
  );

  spi_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
    .active(cs_active), .dev(dev_q), .cs_n(spi_cs_n)
  );
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk #(
  parameter int NUM_CS = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              eng_busy,
  input logic              div_tick,
  input logic              xfer_done,
  input logic              xfer_done_rw,
  input logic              start_accept,
  input logic              stat_re,
  input logic              stat_we,
  input logic              mask_w_q,
  input logic              mask_rw_q,
  input logic              irq,
  input logic              spi_sclk,
  input logic [NUM_CS-1:0] spi_cs_n
);
  assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_busy |-> !spi_sclk);

  assert_sclk_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !div_tick |=> $stable(spi_sclk));

  assert_cs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> &spi_cs_n);

  assert_re_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && xfer_done_rw |=> stat_re);

  assert_we_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !xfer_done_rw |=> stat_we);

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> !start_accept);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mask_w_q && mask_rw_q |-> !irq);
endmodule

bind spi_master_regs spi_master_regs_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .div_tick(div_tick),
  .xfer_done(xfer_done), .xfer_done_rw(xfer_done_rw), .start_accept(start_accept),
  .stat_re(stat_re), .stat_we(stat_we), .mask_w_q(mask_w_q), .mask_rw_q(mask_rw_q),
  .irq(irq), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n)
);

// File: tb/spi_master_regs_tb.sv
`timescale 1ns/1ps
module spi_master_regs_tb;
  localparam int NCS = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, spi_miso = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq, spi_sclk, spi_mosi;
  logic [NCS-1:0] spi_cs_n;

  always #4 clk = ~clk;

  spi_master_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int checks = 0, errors = 0, cyc = 0;

  // behavioural reference state
  bit m_act, m_rw, m_fre, m_fwe;
  int m_t, m_n, m_h, m_dev;
  logic [31:0] m_tx, m_rx, m_pat;
  logic [15:0] m_set1, m_set2, m_txl, m_txh;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] low_mask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 1);
  endfunction

  // model update on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_t = 0; m_n = 1; m_h = 1; m_dev = 0; m_rw = 0;
      m_fre = 0; m_fwe = 0; m_tx = 0; m_rx = 0;
      m_set1 = 0; m_set2 = 0; m_txl = 0; m_txh = 0;
    end else begin
      bit accept;
      accept = bus_wr && bus_addr == 3'd2 && !m_act && m_set1[0]
               && (bus_wdata[0] || bus_wdata[1]);
      if (bus_rd && bus_addr == 3'd3) begin m_fre = 0; m_fwe = 0; end
      if (m_act) begin
        m_t++;
        if (m_t == (2*m_n+1)*m_h) begin
          if (m_rw) begin m_fre = 1; m_rx = m_pat & low_mask(m_n); end
          else m_fwe = 1;
        end
        if (m_t == (2*m_n+15)*m_h) m_act = 0;
      end
      if (accept) begin
        m_act = 1; m_t = 0;
        m_n   = int'(bus_wdata[6:2]) + 1;
        m_dev = int'(bus_wdata[9:7]);
        m_rw  = bus_wdata[0];
        m_h   = int'(m_set2[7:0]) + 1;
        m_tx  = {m_txh, m_txl};
      end
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_set1 = bus_wdata & 16'h0031;
          3'd1: m_set2 = bus_wdata & 16'h00FF;
          3'd4: m_txl  = bus_wdata;
          3'd5: m_txh  = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison and MISO drive on falling edges
  always @(negedge clk) begin
    if (rst_n) begin
      int k;
      bit csw;
      logic [NCS-1:0] exp_cs;
      k   = m_t / m_h;
      csw = m_act && (m_t < (2*m_n+1)*m_h);
      exp_cs = '1;
      if (csw && m_dev < NCS) exp_cs[m_dev] = 1'b0;
      chk(spi_cs_n == exp_cs, "R4/R7 chip select", 32'(spi_cs_n), 32'(exp_cs));
      chk(spi_sclk == (csw && (k % 2 == 1)), "R4 sclk", 32'(spi_sclk), 32'(csw && (k % 2 == 1)));
      if (csw && k < 2*m_n)
        chk(spi_mosi == m_tx[31 - k/2], "R5 mosi", 32'(spi_mosi), 32'(m_tx[31 - k/2]));
      chk(irq == ((m_fre && !m_set1[5]) || (m_fwe && !m_set1[4])), "R9 irq",
          32'(irq), 32'((m_fre && !m_set1[5]) || (m_fwe && !m_set1[4])));
      spi_miso = (csw && k < 2*m_n) ? m_pat[m_n - 1 - k/2] : 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2;
    chk(bus_rdata == exp, req, 32'(bus_rdata), 32'(exp));
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_act) @(negedge clk);
  endtask

  function automatic logic [15:0] ctrl_word(input int dev, input int n, input int mode);
    return 16'((dev << 7) | ((n - 1) << 2) | mode);
  endfunction

  initial begin
    m_pat = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == '1, "R1 cs reset", 32'(spi_cs_n), 32'h1f);
    chk(!spi_sclk && !irq, "R1 sclk/irq reset", 32'({spi_sclk, irq}), 0);
    for (int i = 0; i < 8; i++) begin
      bus_addr = 3'(i); #1;
      chk(bus_rdata == 16'h0, "R1 register reset", 32'(bus_rdata), 0);
    end
    rst_n = 1'b1;

    // R2 map and masks
    wr(3'd0, 16'hFFFF); rd(3'd0, 16'h0031, "R2 SET1 mask");
    wr(3'd1, 16'hABCD); rd(3'd1, 16'h00CD, "R2 SET2 mask");
    wr(3'd4, 16'h1234); rd(3'd4, 16'h1234, "R2 TX_LSB");
    wr(3'd5, 16'h5678); rd(3'd5, 16'h5678, "R2 TX_MSB");

    // R3 R6: 8-bit read-write to device 2, h=2
    wr(3'd0, 16'h0001); wr(3'd1, 16'h0001);
    wr(3'd5, 16'hA5C3); wr(3'd4, 16'h0000);
    m_pat = 32'h3C;
    wr(3'd2, ctrl_word(2, 8, 1));
    wait_idle();
    rd(3'd6, 16'h003C, "R6 rx low right-aligned");
    rd(3'd7, 16'h0000, "R6 rx high zero");
    chk(irq == 1'b1, "R9 irq on read end", 32'(irq), 1);
    rd(3'd3, 16'h0001, "R8 read end flag");
    rd(3'd3, 16'h0000, "R8 status cleared by read");

    // write-only 32 bits, device 0, h=1: rx unchanged
    wr(3'd1, 16'h0000); wr(3'd5, 16'h1234); wr(3'd4, 16'h5678);
    m_pat = 32'hFFFF_FFFF;
    wr(3'd2, ctrl_word(0, 32, 2));
    wait_idle();
    rd(3'd6, 16'h003C, "R6 rx untouched by write-only");
    rd(3'd3, 16'h0002, "R8 write end flag");

    // 1-bit read-write, device 4, h=4
    wr(3'd1, 16'h0003); wr(3'd5, 16'h8000); m_pat = 32'h1;
    wr(3'd2, ctrl_word(4, 1, 1));
    wait_idle();
    rd(3'd6, 16'h0001, "R6 single bit");
    rd(3'd3, 16'h0001, "R8 single bit end");

    // R7 device 6: no chip select, 16-bit read-write with both bits (R11)
    wr(3'd1, 16'h0002); wr(3'd5, 16'hBEEF); m_pat = 32'h0000_9A5C;
    wr(3'd2, ctrl_word(6, 16, 3));
    wait_idle();
    rd(3'd6, 16'h9A5C, "R11 both bits give read-write");
    rd(3'd3, 16'h0001, "R11 read end flag");

    // R9 masks
    wr(3'd0, 16'h0031); m_pat = 32'h5;
    wr(3'd2, ctrl_word(1, 4, 2));
    wait_idle();
    chk(irq == 1'b0, "R9 masked irq", 32'(irq), 0);
    rd(3'd3, 16'h0002, "R9 flag set although masked");
    wr(3'd0, 16'h0021); m_pat = 32'h2;
    wr(3'd2, ctrl_word(1, 3, 2));
    wait_idle();
    chk(irq == 1'b1, "R9 write-end irq enabled", 32'(irq), 1);
    rd(3'd3, 16'h0002, "R9 clear");

    // R3 clock disabled: no start
    wr(3'd0, 16'h0000);
    wr(3'd2, ctrl_word(0, 8, 1));
    repeat (10) @(negedge clk);
    chk(spi_cs_n == '1, "R3 start ignored when disabled", 32'(spi_cs_n), 32'h1f);
    rd(3'd3, 16'h0000, "R3 no flag when disabled");

    // R10 writes during transfer and guard are ignored
    wr(3'd0, 16'h0001); wr(3'd1, 16'h0001); wr(3'd5, 16'hF0F0); m_pat = 32'h6;
    wr(3'd2, ctrl_word(3, 4, 1));
    repeat (3) @(negedge clk);
    wr(3'd2, ctrl_word(0, 32, 2));
    while (!spi_cs_n[3] || m_t < 9*2) @(negedge clk);
    wr(3'd2, ctrl_word(1, 2, 2));
    repeat (2) @(negedge clk);
    chk(spi_cs_n == '1, "R10 guard write ignored", 32'(spi_cs_n), 32'h1f);
    wait_idle();
    rd(3'd3, 16'h0001, "R10 only first transfer ended");
    rd(3'd6, 16'h0006, "R10 rx from first transfer");

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule